// File: doc/BRIEF.md
# Lamp Strike and Fault Sequencer

This block sequences the ignition and protection of a fluorescent lamp driven by a full-bridge converter. A new enable puts it in strike mode. It then commands an operating frequency that starts at twice nominal and falls in equal steps toward half nominal, so that the drive crosses the resonance of the output tank. The sweep ends in one of two ways. If the lamp current reaches its target, the block moves to normal running at nominal frequency. If the voltage limiter engages first, a wait timer starts. When the sweep bottoms out with neither event, the block also starts the wait timer, holding the frequency at half nominal.

During normal running, the voltage limiter taking control without current regulation is read as a suspected open lamp, and the same wait timer is armed. Four protections latch a fault:
- wait-timer expiry;
- over-voltage, which trips at once;
- over-temperature, which trips at once;
- over-current held across more than a set number of main oscillator ticks.

A fault stops switching and drives the active-low fault output. Only a fresh rising edge of enable clears it. The analog comparators are outside this block; their decisions arrive as synchronous single-bit flags.

Top module: `lamp_strike_seq`

## Requirements
- R1: Out of reset, the outputs are at rest: `run_en`=0, `sync_ok`=0, `burst_ok`=0, `fault_n`=1, `freq_cmd`=0.
- R2: In idle, a rising edge on `en` (reset counts as `en` low) gives `run_en`=1 and `freq_cmd`=2*NOM_FREQ one clock later.
- R3: With no event during strike, `freq_cmd` falls by STEP=(3*NOM_FREQ/2)/SWEEP_LEN on each clock, so k clocks after entry it equals 2*NOM_FREQ-k*STEP.
- R4: When `cur_ok` is seen during strike or wait, `freq_cmd` becomes NOM_FREQ and `sync_ok`=`burst_ok`=1 on the next clock. During strike, `cur_ok` takes priority over `vlim`.
- R5: When `vlim` is seen during strike, the sweep freezes at its current value and the wait timer starts. A later `cur_ok` then leads to running as in R4.
- R6: The wait state lasts WAIT_LEN=3*SWEEP_LEN/2 clocks. If `cur_ok` has not been seen in that time, the next clock gives `fault_n`=0 and `run_en`=0.
- R7: If the strike sweep runs SWEEP_LEN clocks with no event, `freq_cmd` goes to NOM_FREQ/2 and holds there while the wait timer runs.
- R8: During running, `vlim` without `cur_ok` drops `sync_ok` and `burst_ok`, keeps `freq_cmd` at NOM_FREQ and starts the same wait timer.
- R9: While `run_en`=1, `ovp` or `otp` gives `fault_n`=0 on the next clock.
- R10: While `run_en`=1, `ocp` seen together with `osc_tick` on OC_TICKS+1 ticks, with no clock of `ocp` low in between, gives `fault_n`=0 on the clock of the last such tick. A single clock of `ocp` low restarts the count.
- R11: A fault persists while `en` stays high. Lowering `en` and raising it again restarts the strike.
- R12: `en` low on any clock gives `run_en`=0, `fault_n`=1 and `freq_cmd`=0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; its rising edge starts a strike |
| cur_ok | input | 1 | Lamp current at target (current loop in control) |
| vlim | input | 1 | Voltage limiter in control |
| ovp | input | 1 | Over-voltage comparator result |
| ocp | input | 1 | Over-current comparator result |
| otp | input | 1 | Over-temperature flag |
| osc_tick | input | 1 | One-clock pulse per main oscillator period |
| freq_cmd | output | FREQ_W | Operating frequency command, in units of NOM_FREQ/1024 at default |
| run_en | output | 1 | Bridge switching allowed |
| sync_ok | output | 1 | External synchronisation allowed |
| burst_ok | output | 1 | Burst dimming allowed |
| fault_n | output | 1 | Fault, active low, meant for an open-drain pad |

## Verification
All outputs are decoded from registers. A flag sampled at one clock edge therefore shows on the outputs just after that edge, and the over-current trip lands on the edge that samples its final tick. The bench drives inputs just after a falling edge. A behavioural model advances on each rising edge, and outputs are compared with it at every falling edge, half a period after they settle. Directed checks count edges: the sweep is checked at the 63rd and 64th clock after entry, and the wait timer at its 95th and 96th clock.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_STRIKE, ST_WAIT, ST_RUN, ST_FAULT
  } lss_state_e;

  typedef enum logic [2:0] {
    FC_HOLD, FC_START, FC_STEP, FC_NOM, FC_HALF, FC_ZERO
  } lss_fctl_e;
endpackage

// File: rtl/lss_oc_filter.sv
module lss_oc_filter #(
  parameter int OC_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ocp,
  input  logic osc_tick,
  output logic trip
);
  localparam int CW = $clog2(OC_TICKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          at_lim;

  assign at_lim = (cnt_q == CW'(OC_TICKS));
  assign trip   = active & ocp & osc_tick & at_lim;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!(active && ocp)) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (osc_tick && !at_lim) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lss_freq_gen.sv
module lss_freq_gen
  import lss_pkg::*;
#(
  parameter int NOM_FREQ = 1024,
  parameter int STEP     = 24,
  parameter int FREQ_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lss_fctl_e         ctl,
  output logic [FREQ_W-1:0] freq
);
  logic [FREQ_W-1:0] freq_d;
  logic              freq_en;

  assign freq_en = (ctl != FC_HOLD);

  always_comb begin
    case (ctl)
      FC_START: freq_d = FREQ_W'(2 * NOM_FREQ);
      FC_STEP:  freq_d = freq - FREQ_W'(STEP);
      FC_NOM:   freq_d = FREQ_W'(NOM_FREQ);
      FC_HALF:  freq_d = FREQ_W'(NOM_FREQ / 2);
      FC_ZERO:  freq_d = '0;
      default:  freq_d = freq;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       freq <= '0;
    else if (freq_en) freq <= freq_d;
  end
endmodule

// File: rtl/lss_ctrl.sv
module lss_ctrl
  import lss_pkg::*;
#(
  parameter int SWEEP_LEN = 64,
  parameter int WAIT_LEN  = 96,
  parameter int CNT_W     = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       cur_ok,
  input  logic       vlim,
  input  logic       trip,
  output lss_state_e state,
  output lss_fctl_e  fctl
);
  lss_state_e       st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_q;

  always_comb begin
    st_d  = state;
    cnt_d = cnt_q;
    fctl  = FC_HOLD;
    if (!en) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
      fctl  = FC_ZERO;
    end else begin
      case (state)
        ST_IDLE: if (!en_q) begin
          st_d  = ST_STRIKE;
          cnt_d = '0;
          fctl  = FC_START;
        end
        ST_STRIKE, ST_WAIT, ST_RUN: begin
          if (trip) begin
            st_d = ST_FAULT;
            fctl = FC_ZERO;
          end else if (state == ST_RUN) begin
            if (vlim && !cur_ok) begin
              st_d  = ST_WAIT;
              cnt_d = '0;
            end
          end else if (cur_ok) begin
            st_d = ST_RUN;
            fctl = FC_NOM;
          end else if (state == ST_WAIT) begin
            if (cnt_q == CNT_W'(WAIT_LEN - 1)) begin
              st_d = ST_FAULT;
              fctl = FC_ZERO;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end else if (vlim) begin
            st_d  = ST_WAIT;
            cnt_d = '0;
          end else if (cnt_q == CNT_W'(SWEEP_LEN - 1)) begin
            st_d  = ST_WAIT;
            cnt_d = '0;
            fctl  = FC_HALF;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
            fctl  = FC_STEP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      state <= st_d;
      cnt_q <= cnt_d;
      en_q  <= en;
    end
  end
endmodule

// File: rtl/lamp_strike_seq.sv
module lamp_strike_seq
  import lss_pkg::*;
#(
  parameter int NOM_FREQ  = 1024,
  parameter int SWEEP_LEN = 64,
  parameter int OC_TICKS  = 4,
  parameter int FREQ_W    = $clog2(2 * NOM_FREQ + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cur_ok,
  input  logic              vlim,
  input  logic              ovp,
  input  logic              ocp,
  input  logic              otp,
  input  logic              osc_tick,
  output logic [FREQ_W-1:0] freq_cmd,
  output logic              run_en,
  output logic              sync_ok,
  output logic              burst_ok,
  output logic              fault_n
);
  localparam int WAIT_LEN = (3 * SWEEP_LEN) / 2;
  localparam int STEP     = (3 * NOM_FREQ / 2) / SWEEP_LEN;
  localparam int CNT_W    = $clog2(WAIT_LEN + 1);

  lss_state_e state;
  lss_fctl_e  fctl;
  logic       oc_trip, trip;

  assign run_en   = (state == ST_STRIKE) || (state == ST_WAIT) || (state == ST_RUN);
  assign sync_ok  = (state == ST_RUN);
  assign burst_ok = (state == ST_RUN);
  assign fault_n  = (state != ST_FAULT);
  assign trip     = ovp | otp | oc_trip;

  lss_oc_filter #(.OC_TICKS(OC_TICKS)) u_ocf (
    .clk(clk), .rst_n(rst_n), .active(run_en), .ocp(ocp),
    .osc_tick(osc_tick), .trip(oc_trip)
  );

  lss_ctrl #(.SWEEP_LEN(SWEEP_LEN), .WAIT_LEN(WAIT_LEN), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .cur_ok(cur_ok), .vlim(vlim),
    .trip(trip), .state(state), .fctl(fctl)
  );

  lss_freq_gen #(.NOM_FREQ(NOM_FREQ), .STEP(STEP), .FREQ_W(FREQ_W)) u_freq (
    .clk(clk), .rst_n(rst_n), .ctl(fctl), .freq(freq_cmd)
  );
endmodule

// File: rtl/lss_checker.sv
module lss_checker #(
  parameter int NOM_FREQ = 1024,
  parameter int FREQ_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              ovp,
  input logic              otp,
  input logic [FREQ_W-1:0] freq_cmd,
  input logic              run_en,
  input logic              sync_ok,
  input logic              burst_ok,
  input logic              fault_n
);
  assert_strike_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en) && fault_n && !run_en) |=> (run_en && freq_cmd == FREQ_W'(2 * NOM_FREQ)));

  assert_sweep_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !sync_ok && $past(run_en) && !$past(sync_ok)) |-> (freq_cmd <= $past(freq_cmd)));

  assert_run_nominal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ok |-> (burst_ok && run_en && freq_cmd == FREQ_W'(NOM_FREQ)));

  assert_prot_trip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run_en && (ovp || otp)) |=> !fault_n);

  assert_fault_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !fault_n) |=> (!fault_n && !run_en));

  assert_disable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!run_en && fault_n && freq_cmd == '0));
endmodule

bind lamp_strike_seq lss_checker #(.NOM_FREQ(NOM_FREQ), .FREQ_W(FREQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ovp(ovp), .otp(otp), .freq_cmd(freq_cmd),
  .run_en(run_en), .sync_ok(sync_ok), .burst_ok(burst_ok), .fault_n(fault_n)
);

// File: tb/lamp_strike_seq_tb.sv
`timescale 1ns/1ps
module lamp_strike_seq_tb;
  localparam int NOM   = 1024;
  localparam int SWL   = 64;
  localparam int OCT   = 4;
  localparam int FW    = 12;
  localparam int WTL   = (3 * SWL) / 2;
  localparam int STP   = (3 * NOM / 2) / SWL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cur_ok = 1'b0, vlim = 1'b0, ovp = 1'b0, ocp = 1'b0, otp = 1'b0, osc_tick = 1'b0;
  logic [FW-1:0] freq_cmd;
  logic run_en, sync_ok, burst_ok, fault_n;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  lamp_strike_seq #(.NOM_FREQ(NOM), .SWEEP_LEN(SWL), .OC_TICKS(OCT)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cur_ok(cur_ok), .vlim(vlim), .ovp(ovp),
    .ocp(ocp), .otp(otp), .osc_tick(osc_tick), .freq_cmd(freq_cmd), .run_en(run_en),
    .sync_ok(sync_ok), .burst_ok(burst_ok), .fault_n(fault_n)
  );

  // behavioural reference: 0 idle, 1 strike, 2 wait, 3 run, 4 fault
  int m_st = 0, m_cnt = 0, m_freq = 0, m_oc = 0;
  bit m_enq = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_freq = 0; m_oc = 0; m_enq = 0;
    end else begin
      bit act, trp;
      act = (m_st >= 1 && m_st <= 3);
      trp = ovp || otp || (act && ocp && osc_tick && m_oc == OCT);
      if (!(act && ocp)) m_oc = 0;
      else if (osc_tick && m_oc < OCT) m_oc++;
      if (!en) begin
        m_st = 0; m_freq = 0; m_cnt = 0;
      end else if (m_st == 0) begin
        if (!m_enq) begin m_st = 1; m_freq = 2 * NOM; m_cnt = 0; end
      end else if (act && trp) begin
        m_st = 4; m_freq = 0;
      end else if (m_st == 3) begin
        if (vlim && !cur_ok) begin m_st = 2; m_cnt = 0; end
      end else if (act && cur_ok) begin
        m_st = 3; m_freq = NOM;
      end else if (m_st == 2) begin
        if (m_cnt == WTL - 1) begin m_st = 4; m_freq = 0; end
        else m_cnt++;
      end else if (m_st == 1) begin
        if (vlim) begin m_st = 2; m_cnt = 0; end
        else if (m_cnt == SWL - 1) begin m_st = 2; m_cnt = 0; m_freq = NOM / 2; end
        else begin m_cnt++; m_freq -= STP; end
      end
      m_enq = en;
    end
  end

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk({tag, " freq_cmd"}, int'(freq_cmd), m_freq);
      chk({tag, " run_en"},   int'(run_en),   int'(m_st >= 1 && m_st <= 3));
      chk({tag, " sync_ok"},  int'(sync_ok),  int'(m_st == 3));
      chk({tag, " burst_ok"}, int'(burst_ok), int'(m_st == 3));
      chk({tag, " fault_n"},  int'(fault_n),  int'(m_st != 4));
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic otick();
    osc_tick = 1'b1; tick(); osc_tick = 1'b0; tick(2);
  endtask

  task automatic restart_to_run();
    en = 1'b0; tick(); en = 1'b1; tick();
    cur_ok = 1'b1; tick(); cur_ok = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    tag = "R1";
    chk("R1 freq at rest", int'(freq_cmd), 0);
    chk("R1 fault_n at rest", int'(fault_n), 1);
    chk("R1 run_en at rest", int'(run_en), 0);

    tag = "R2"; en = 1'b1; tick();
    chk("R2 strike start freq", int'(freq_cmd), 2 * NOM);
    chk("R2 strike run_en", int'(run_en), 1);

    tag = "R3"; tick(10);
    chk("R3 sweep after 10", int'(freq_cmd), 2 * NOM - 10 * STP);

    tag = "R4"; cur_ok = 1'b1; vlim = 1'b1; tick(); cur_ok = 1'b0; vlim = 1'b0;
    chk("R4 nominal freq", int'(freq_cmd), NOM);
    chk("R4 sync_ok", int'(sync_ok), 1);
    chk("R4 burst_ok", int'(burst_ok), 1);

    tag = "R8"; vlim = 1'b1; tick();
    chk("R8 sync dropped", int'(sync_ok), 0);
    chk("R8 freq kept nominal", int'(freq_cmd), NOM);
    tick(20);
    tag = "R5"; vlim = 1'b0; cur_ok = 1'b1; tick(); cur_ok = 1'b0;
    chk("R5 back to run", int'(sync_ok), 1);

    tag = "R12"; en = 1'b0; tick();
    chk("R12 run_en low", int'(run_en), 0);
    chk("R12 freq zero", int'(freq_cmd), 0);

    tag = "R7"; en = 1'b1; tick(); tick(63);
    chk("R7 last sweep step", int'(freq_cmd), 2 * NOM - 63 * STP);
    tick();
    chk("R7 hold half", int'(freq_cmd), NOM / 2);
    tag = "R6"; tick(WTL - 1);
    chk("R6 still waiting", int'(fault_n), 1);
    tick();
    chk("R6 timeout fault", int'(fault_n), 0);
    chk("R6 switching off", int'(run_en), 0);

    tag = "R11"; tick(10);
    chk("R11 fault latched", int'(fault_n), 0);
    en = 1'b0; tick();
    chk("R11 cleared by en low", int'(fault_n), 1);
    en = 1'b1; tick();
    chk("R11 restrike", int'(freq_cmd), 2 * NOM);

    tag = "R5"; tick(5); vlim = 1'b1; tick();
    chk("R5 sweep frozen", int'(freq_cmd), 2 * NOM - 5 * STP);
    tick(8); vlim = 1'b0;
    chk("R5 still frozen", int'(freq_cmd), 2 * NOM - 5 * STP);
    cur_ok = 1'b1; tick(); cur_ok = 1'b0;
    chk("R5 run after wait", int'(sync_ok), 1);

    tag = "R10"; ocp = 1'b1;
    for (int i = 0; i < 3; i++) otick();
    ocp = 1'b0; tick(); ocp = 1'b1;
    for (int i = 0; i < OCT; i++) otick();
    chk("R10 no trip at limit", int'(fault_n), 1);
    osc_tick = 1'b1; tick(); osc_tick = 1'b0;
    chk("R10 trip on extra tick", int'(fault_n), 0);
    ocp = 1'b0;

    tag = "R9"; restart_to_run(); tick(3); ovp = 1'b1; tick(); ovp = 1'b0;
    chk("R9 over-voltage", int'(fault_n), 0);
    restart_to_run(); otp = 1'b1; tick(); otp = 1'b0;
    chk("R9 over-temperature", int'(fault_n), 0);

    tick(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule